// File: doc/BRIEF.md
# DDR SDRAM mode programming sequencer

This block sits on the controller side of a DDR SDRAM and brings the memory's mode registers into a known setting before any read is allowed. A one-cycle start request captures the requested configuration: burst length code, burst type, CAS latency selection, output drive strength and DLL enable. The block then drives three load-mode-register commands in a fixed order. The first writes the extended register. The second is a base-register load that resets the DLL. The third is a base-register load that selects normal operation. Between commands the block drives NOP. It holds a load back for as long as the bank-idle status input is low.

After the last load the block reports that programming is finished. It keeps the read-permitted output low until at least 200 clock cycles with clock enable high have passed since the DLL was set up by the extended-register load. A CAS latency selection that cannot be encoded is refused at start. The block then raises an error flag and issues no command.

States, each named: ST_IDLE (after reset), ST_EMR (waiting to issue the extended load), ST_GAP_A (spacing after it), ST_DLLRST (waiting to issue the DLL-reset load), ST_GAP_B (spacing after it), ST_NORM (waiting to issue the normal load), ST_LOCK (lock wait), ST_DONE (reads allowed) and ST_ERROR (refused configuration). Transitions are:
- start accepted: ST_IDLE, ST_DONE or ST_ERROR go to ST_EMR for a legal latency, or to ST_ERROR for an illegal one.
- load issued: each ST_EMR, ST_DLLRST or ST_NORM state moves on when bank-idle is high.
- gap over: ST_GAP_A goes to ST_DLLRST and ST_GAP_B goes to ST_NORM.
- lock reached: ST_LOCK goes to ST_DONE.

Top module: `ddr_mode_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the command is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and ready_o, read_ok_o and cfg_error_o are 0. cke_o is 0 during reset and 1 from the first clock edge after release.
- R2: A legal start produces exactly three load commands (cs_n, ras_n, cas_n and we_n all 0), in this order: extended load with ba_o=2'b01, then a base load with ba_o=2'b00 and addr_o[8]=1, then a base load with ba_o=2'b00 and addr_o[8]=0. Every other cycle drives NOP.
- R3: The extended load carries addr_o[0]=NOT dll_enable_i and addr_o[1]=drive_reduced_i, with all higher address bits 0.
- R4: Both base loads carry addr_o[2:0]=burst_len_i and addr_o[3]=burst_interleave_i. They carry addr_o[6:4]=010, 110 or 011 for cas_sel_i = 0 (latency 2), 1 (latency 2.5) or 2 (latency 3). addr_o[7] and addr_o[12:9] are 0.
- R5: A start with cas_sel_i of 3 to 7 sets cfg_error_o one cycle later and issues no load. A later legal start clears cfg_error_o one cycle after it is accepted.
- R6: A load is issued only in the cycle after a clock edge at which banks_idle_i was high while the sequencer waited to issue. NOP is held while the input is low.
- R7: Consecutive loads are separated by exactly max(gap_cycles_i,1) NOP cycles when banks_idle_i is high, using the gap value captured at start. The first load follows the start edge by two cycles.
- R8: read_ok_o first goes high in cycle max(E+200, N+1), where E is the cycle of the extended load and N the cycle of the normal load. It is low in every earlier cycle, including the 199 counted cycles after E.
- R9: ready_o goes high in the cycle the normal load is driven and stays high until the next start is accepted. Accepting a start clears both ready_o and read_ok_o.
- R10: Configuration inputs are captured at the accepted start. Changing them afterwards has no effect on the loads of that sequence.
- R11: A start request while loads or the lock wait are in progress is ignored. The sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the programming sequence |
| burst_len_i | input | 3 | Burst length code for mode bits 2:0 |
| burst_interleave_i | input | 1 | Burst type: 1 interleaved, 0 sequential |
| cas_sel_i | input | 3 | Latency selection: 0=2, 1=2.5, 2=3, others illegal |
| drive_reduced_i | input | 1 | Reduced output drive request |
| dll_enable_i | input | 1 | DLL enable request |
| banks_idle_i | input | 1 | All banks idle and no burst active |
| gap_cycles_i | input | GAP_W | Minimum NOP cycles between loads (0 treated as 1) |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| cke_o | output | 1 | Clock enable level |
| ready_o | output | 1 | All three loads issued |
| read_ok_o | output | 1 | Reads permitted |
| cfg_error_o | output | 1 | Last start refused for an illegal latency |

## Verification
All outputs are registered. A start sampled at one edge sets the error flag, or clears it and the done flags, in the cycle after that edge. A load appears in the cycle after the edge at which bank-idle was seen high in a waiting state. The next waiting state begins max(gap,1) cycles after a load, and read-permitted rises at the later of 200 cycles after the extended load and one cycle after the normal load. The bench drives inputs and samples outputs on the falling edge. It keeps a cycle index and the bank-idle value it drove in each cycle, and from these it predicts, cycle by cycle, whether a load or a NOP is due and what ready and read-permitted must show.

// File: rtl/ddr_mode_pkg.sv
`timescale 1ns/1ps
package ddr_mode_pkg;

    localparam int BA_W = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EMR,
        ST_GAP_A,
        ST_DLLRST,
        ST_GAP_B,
        ST_NORM,
        ST_LOCK,
        ST_DONE,
        ST_ERROR
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam logic [BA_W-1:0] BANK_BASE = 2'b00;
    localparam logic [BA_W-1:0] BANK_EXT  = 2'b01;

endpackage

// File: rtl/cas_lat_encoder.sv
`timescale 1ns/1ps
module cas_lat_encoder (
    input  logic [2:0] sel_i,
    output logic [2:0] code_o,
    output logic       valid_o
);
    always_comb begin
        code_o  = 3'b000;
        valid_o = 1'b0;
        case (sel_i)
            3'd0: begin code_o = 3'b010; valid_o = 1'b1; end
            3'd1: begin code_o = 3'b110; valid_o = 1'b1; end
            3'd2: begin code_o = 3'b011; valid_o = 1'b1; end
            default: begin code_o = 3'b000; valid_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mode_word_builder.sv
`timescale 1ns/1ps
module mode_word_builder #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len_i,
    input  logic              interleave_i,
    input  logic [2:0]        cl_code_i,
    input  logic              drive_reduced_i,
    input  logic              dll_enable_i,
    output logic [ADDR_W-1:0] ext_word_o,
    output logic [ADDR_W-1:0] dllrst_word_o,
    output logic [ADDR_W-1:0] normal_word_o
);
    localparam int DLLRST_BIT = 8;

    logic [ADDR_W-1:0] base_word;

    always_comb begin
        base_word      = '0;
        base_word[2:0] = burst_len_i;
        base_word[3]   = interleave_i;
        base_word[6:4] = cl_code_i;
    end

    always_comb begin
        ext_word_o    = '0;
        ext_word_o[0] = ~dll_enable_i;
        ext_word_o[1] = drive_reduced_i;
    end

    always_comb begin
        dllrst_word_o             = base_word;
        dllrst_word_o[DLLRST_BIT] = 1'b1;
        normal_word_o             = base_word;
    end
endmodule

// File: rtl/cycle_counter.sv
`timescale 1ns/1ps
module cycle_counter #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX_V = W'(MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clear_i) begin
            cnt_o <= '0;
        end else if (en_i && (cnt_o != MAX_V)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/ddr_mode_seq.sv
`timescale 1ns/1ps
module ddr_mode_seq
    import ddr_mode_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int GAP_W       = 4,
    parameter int LOCK_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        burst_len_i,
    input  logic              burst_interleave_i,
    input  logic [2:0]        cas_sel_i,
    input  logic              drive_reduced_i,
    input  logic              dll_enable_i,
    input  logic              banks_idle_i,
    input  logic [GAP_W-1:0]  gap_cycles_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cke_o,
    output logic              ready_o,
    output logic              read_ok_o,
    output logic              cfg_error_o
);
    localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
    localparam int GAP_MAX = (1 << GAP_W) - 1;
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

    seq_state_t state_q, state_nx;
    ddr_cmd_t   cmd_q;

    logic [2:0]        cl_code_raw;
    logic              cl_valid_raw;
    logic [2:0]        cap_bl;
    logic              cap_bt;
    logic [2:0]        cap_cl;
    logic              cap_dw;
    logic              cap_dle;
    logic [GAP_W-1:0]  cap_gap;
    logic [ADDR_W-1:0] ext_word, dllrst_word, normal_word;
    logic [GAP_W-1:0]  gap_cnt;
    logic [LOCK_W-1:0] lock_cnt;
    logic              cke_q;

    logic start_ok, load_ext, load_dllrst, load_norm, any_load;
    logic in_gap, gap_done, lock_done;

    cas_lat_encoder u_cl_enc (
        .sel_i   (cas_sel_i),
        .code_o  (cl_code_raw),
        .valid_o (cl_valid_raw)
    );

    mode_word_builder #(.ADDR_W(ADDR_W)) u_words (
        .burst_len_i     (cap_bl),
        .interleave_i    (cap_bt),
        .cl_code_i       (cap_cl),
        .drive_reduced_i (cap_dw),
        .dll_enable_i    (cap_dle),
        .ext_word_o      (ext_word),
        .dllrst_word_o   (dllrst_word),
        .normal_word_o   (normal_word)
    );

    cycle_counter #(.W(GAP_W), .MAX(GAP_MAX)) u_gap_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (any_load),
        .en_i    (in_gap),
        .cnt_o   (gap_cnt)
    );

    cycle_counter #(.W(LOCK_W), .MAX(LOCK_CYCLES)) u_lock_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_ext),
        .en_i    (cke_q),
        .cnt_o   (lock_cnt)
    );

    // Event decode
    always_comb begin
        start_ok    = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE) ||
                                  (state_q == ST_ERROR));
        load_ext    = (state_q == ST_EMR)    && banks_idle_i;
        load_dllrst = (state_q == ST_DLLRST) && banks_idle_i;
        load_norm   = (state_q == ST_NORM)   && banks_idle_i;
        any_load    = load_ext || load_dllrst || load_norm;
        in_gap      = (state_q == ST_GAP_A) || (state_q == ST_GAP_B);
        gap_done    = gap_cnt >= (cap_gap - 1'b1);
        lock_done   = lock_cnt >= LOCK_LAST;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERROR:
                if (start_i) state_nx = cl_valid_raw ? ST_EMR : ST_ERROR;
            ST_EMR:    if (banks_idle_i) state_nx = ST_GAP_A;
            ST_GAP_A:  if (gap_done)     state_nx = ST_DLLRST;
            ST_DLLRST: if (banks_idle_i) state_nx = ST_GAP_B;
            ST_GAP_B:  if (gap_done)     state_nx = ST_NORM;
            ST_NORM:   if (banks_idle_i) state_nx = ST_LOCK;
            ST_LOCK:   if (lock_done)    state_nx = ST_DONE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // Configuration capture at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bl  <= '0;
            cap_bt  <= 1'b0;
            cap_cl  <= 3'b010;
            cap_dw  <= 1'b0;
            cap_dle <= 1'b1;
            cap_gap <= GAP_W'(1);
        end else if (start_ok && cl_valid_raw) begin
            cap_bl  <= burst_len_i;
            cap_bt  <= burst_interleave_i;
            cap_cl  <= cl_code_raw;
            cap_dw  <= drive_reduced_i;
            cap_dle <= dll_enable_i;
            cap_gap <= (gap_cycles_i == '0) ? GAP_W'(1) : gap_cycles_i;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= CMD_NOP;
            ba_o        <= '0;
            addr_o      <= '0;
            cke_q       <= 1'b0;
            ready_o     <= 1'b0;
            read_ok_o   <= 1'b0;
            cfg_error_o <= 1'b0;
        end else begin
            cke_q  <= 1'b1;
            cmd_q  <= CMD_NOP;
            ba_o   <= '0;
            addr_o <= '0;
            if (load_ext) begin
                cmd_q  <= CMD_LMR;
                ba_o   <= BANK_EXT;
                addr_o <= ext_word;
            end else if (load_dllrst) begin
                cmd_q  <= CMD_LMR;
                ba_o   <= BANK_BASE;
                addr_o <= dllrst_word;
            end else if (load_norm) begin
                cmd_q  <= CMD_LMR;
                ba_o   <= BANK_BASE;
                addr_o <= normal_word;
            end
            if (start_ok) begin
                ready_o     <= 1'b0;
                read_ok_o   <= 1'b0;
                cfg_error_o <= ~cl_valid_raw;
            end
            if (load_norm) ready_o <= 1'b1;
            if ((state_q == ST_LOCK) && lock_done) read_ok_o <= 1'b1;
        end
    end

    assign cs_n_o  = cmd_q.cs_n;
    assign ras_n_o = cmd_q.ras_n;
    assign cas_n_o = cmd_q.cas_n;
    assign we_n_o  = cmd_q.we_n;
    assign cke_o   = cke_q;

    // Assertions
    logic lmr_out;
    assign lmr_out = (cmd_q == CMD_LMR);

    assert_load_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_out |=> (cmd_q == CMD_NOP));

    assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_out |-> $past(banks_idle_i));

    assert_legal_cl_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr_out && (ba_o == BANK_BASE)) |->
            ((addr_o[6:4] == 3'b010) || (addr_o[6:4] == 3'b110) || (addr_o[6:4] == 3'b011)));

    assert_error_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error_o |-> (cmd_q == CMD_NOP));

    assert_read_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok_o |-> ready_o);

    assert_read_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_ok_o) |-> (lock_cnt >= LOCK_LAST));

endmodule

// File: tb/test_ddr_mode_seq.sv
`timescale 1ns/1ps
module test_ddr_mode_seq;

    localparam int ADDR_W = 13;
    localparam int GAP_W  = 4;
    localparam int LOCK   = 200;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic [2:0]        burst_len_i;
    logic              burst_interleave_i;
    logic [2:0]        cas_sel_i;
    logic              drive_reduced_i;
    logic              dll_enable_i;
    logic              banks_idle_i;
    logic [GAP_W-1:0]  gap_cycles_i;
    logic              cs_n_o, ras_n_o, cas_n_o, we_n_o;
    logic [1:0]        ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic              cke_o, ready_o, read_ok_o, cfg_error_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ddr_mode_seq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .LOCK_CYCLES(LOCK)) i_ddr_mode_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_len_i(burst_len_i),
        .burst_interleave_i(burst_interleave_i), .cas_sel_i(cas_sel_i),
        .drive_reduced_i(drive_reduced_i), .dll_enable_i(dll_enable_i),
        .banks_idle_i(banks_idle_i), .gap_cycles_i(gap_cycles_i),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .ba_o(ba_o), .addr_o(addr_o), .cke_o(cke_o), .ready_o(ready_o),
        .read_ok_o(read_ok_o), .cfg_error_o(cfg_error_o)
    );

    function automatic logic [2:0] exp_cl(input logic [2:0] sel);
        case (sel)
            3'd0:    return 3'b010;
            3'd1:    return 3'b110;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] exp_ext(input logic dw, input logic dle);
        logic [ADDR_W-1:0] w = '0;
        w[0] = ~dle;
        w[1] = dw;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_base(input logic [2:0] bl, input logic bt,
                                                   input logic [2:0] sel, input logic rst);
        logic [ADDR_W-1:0] w = '0;
        w[2:0] = bl;
        w[3]   = bt;
        w[6:4] = exp_cl(sel);
        w[8]   = rst;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] cmd_now();
        return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    endfunction

    task automatic run_seq(input logic [2:0] bl, input logic bt, input logic [2:0] sel,
                           input logic dw, input logic dle, input int g,
                           input int idle_pct, input bit scramble);
        int  geff = (g == 0) ? 1 : g;
        int  e = 1;
        int  loads = 0;
        int  emr = -1000;
        int  norm = -1000;
        bit  idle_prev;
        bit  exp_load, exp_ready, exp_rok;
        bit  seen_rok = 0;
        int  tail = 0;
        @(negedge clk);
        burst_len_i        = bl;
        burst_interleave_i = bt;
        cas_sel_i          = sel;
        drive_reduced_i    = dw;
        dll_enable_i       = dle;
        gap_cycles_i       = GAP_W'(g);
        start_i            = 1'b1;
        idle_prev          = ($urandom_range(99) < idle_pct);
        banks_idle_i       = idle_prev;
        for (int n = 1; n <= 1200; n++) begin
            @(negedge clk);
            start_i  = 1'b0;
            exp_load = (loads < 3) && idle_prev && ((n - 1) >= e);
            if (exp_load) begin
                loads++;
                if (loads == 1) emr = n;
                if (loads == 3) norm = n;
                e = n + geff;
            end
            exp_ready = (loads == 3);
            exp_rok   = (loads == 3) && (n >= emr + LOCK) && (n >= norm + 1);
            if (exp_load) begin
                check(cmd_now() == 4'b0000, "R2 load command", 32'(cmd_now()), 32'h0);
                if (loads == 1) begin
                    check(ba_o == 2'b01, "R2 extended bank", 32'(ba_o), 32'h1);
                    check(addr_o == exp_ext(dw, dle), "R3 extended word R10",
                          32'(addr_o), 32'(exp_ext(dw, dle)));
                end else begin
                    check(ba_o == 2'b00, "R2 base bank", 32'(ba_o), 32'h0);
                    check(addr_o == exp_base(bl, bt, sel, loads == 2), "R4 base word R10",
                          32'(addr_o), 32'(exp_base(bl, bt, sel, loads == 2)));
                end
            end else begin
                check(cmd_now() == 4'b0111, "R7 R6 NOP between loads", 32'(cmd_now()), 32'h7);
            end
            check(ready_o == exp_ready, "R9 ready", 32'(ready_o), 32'(exp_ready));
            check(read_ok_o == exp_rok, "R8 read permitted", 32'(read_ok_o), 32'(exp_rok));
            check(cfg_error_o == 1'b0, "R5 error clear on legal start", 32'(cfg_error_o), 32'h0);
            if (exp_rok) seen_rok = 1;
            idle_prev    = ($urandom_range(99) < idle_pct);
            banks_idle_i = idle_prev;
            if (scramble) begin
                burst_len_i        = 3'($urandom_range(7));
                burst_interleave_i = 1'($urandom_range(1));
                cas_sel_i          = 3'($urandom_range(7));
                drive_reduced_i    = 1'($urandom_range(1));
                dll_enable_i       = 1'($urandom_range(1));
                gap_cycles_i       = GAP_W'($urandom_range(15));
                if (!exp_rok) start_i = ($urandom_range(9) == 0); // R11
            end
            if (seen_rok) begin
                tail++;
                if (tail > 2) break;
            end
        end
        start_i = 1'b0;
        check(loads == 3, "R2 three loads", 32'(loads), 32'h3);
        check(seen_rok == 1'b1, "R8 reads eventually permitted", 32'(seen_rok), 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        start_i = 1'b0;
        burst_len_i = 3'd0;
        burst_interleave_i = 1'b0;
        cas_sel_i = 3'd0;
        drive_reduced_i = 1'b0;
        dll_enable_i = 1'b1;
        banks_idle_i = 1'b1;
        gap_cycles_i = '0;
        repeat (3) @(negedge clk);
        check(cmd_now() == 4'b0111, "R1 reset command", 32'(cmd_now()), 32'h7);
        check(cke_o == 1'b0, "R1 reset cke", 32'(cke_o), 32'h0);
        check({ready_o, read_ok_o, cfg_error_o} == 3'b000, "R1 reset flags",
              32'({ready_o, read_ok_o, cfg_error_o}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke_o == 1'b1, "R1 cke after release", 32'(cke_o), 32'h1);
        check(cmd_now() == 4'b0111, "R1 command after release", 32'(cmd_now()), 32'h7);
        check({ready_o, read_ok_o} == 2'b00, "R1 flags after release",
              32'({ready_o, read_ok_o}), 32'h0);

        // Directed: tight spacing, bank always idle, latency 2
        run_seq(3'b010, 1'b0, 3'd0, 1'b0, 1'b1, 1, 100, 1'b0);
        // Directed: zero gap treated as one, interleaved, latency 2.5, DLL disabled
        run_seq(3'b011, 1'b1, 3'd1, 1'b1, 1'b0, 0, 100, 1'b0);
        // Directed: widest gap, sparse bank idle, scrambled inputs and starts, latency 3
        run_seq(3'b001, 1'b1, 3'd2, 1'b1, 1'b1, 15, 30, 1'b1);

        // Directed: illegal latency values (R5)
        for (int bad = 3; bad <= 7; bad++) begin
            @(negedge clk);
            cas_sel_i    = 3'(bad);
            banks_idle_i = 1'b1;
            start_i      = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(cfg_error_o == 1'b1, "R5 error raised", 32'(cfg_error_o), 32'h1);
            check({ready_o, read_ok_o} == 2'b00, "R5 R9 flags cleared by start",
                  32'({ready_o, read_ok_o}), 32'h0);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check(cmd_now() == 4'b0111, "R5 no load after refusal", 32'(cmd_now()), 32'h7);
            end
        end

        // Directed: long bank-busy stretches
        run_seq(3'b010, 1'b0, 3'd2, 1'b0, 1'b1, 3, 8, 1'b0);

        // Random runs
        for (int r = 0; r < 8; r++) begin
            run_seq(3'($urandom_range(7)), 1'($urandom_range(1)), 3'($urandom_range(2)),
                    1'($urandom_range(1)), 1'($urandom_range(1)), int'($urandom_range(15)),
                    int'($urandom_range(100, 20)), 1'($urandom_range(1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule